// File: doc/BRIEF.md
# Seven-Bit PWM Waveform Generator

This block turns a 7-bit duty code into a pulse-width-modulated waveform. A period is 128 slots long. A 5-bit frequency select sets a prescaler, and each slot lasts that many clock cycles. Within a period the output is high from slot 0 for as many slots as the duty code says. Two codes are special. Code 0 keeps the output low. Code 127 keeps it high for the whole period, so the 127/128 step is never produced.

The block samples the duty code and the frequency select only at a period boundary, so a change made partway through a period never cuts a pulse short. A one-cycle strobe marks the start of every period. A sequencer that ramps the duty code can use it to line its updates up with the waveform. A frequency select of 0 is invalid. While it is applied, the block stays idle with the output low. It starts a new period one cycle after a valid select appears.

Top module: `pwm7_gen`

## Requirements
- R1: With duty code 0 latched, `pwmOut` stays low for every cycle of the period.
- R2: With a duty code c from 1 to 126 latched and frequency select N, `pwmOut` is high for exactly c·N cycles of each period. These high cycles form one run that starts on the period's first cycle.
- R3: With duty code 127 latched, `pwmOut` is high on every cycle of the period.
- R4: While the frequency select is 0, `pwmOut` stays low and `periodStart` never pulses, for any duty code.
- R5: With frequency select N from 1 to 31, each slot lasts N clock cycles, and a period lasts 128·N cycles from one strobe to the next.
- R6: `periodStart` is high for exactly one clock cycle, which is the first cycle of slot 0 of each period.
- R7: If the duty code changes partway through a period, the running period keeps the old code. The new code applies from the next period.
- R8: If the frequency select changes partway through a period, the running period keeps its length. The new ratio applies from the next period.
- R9: While `rst` is high, and on the first cycle after it is sampled high, `pwmOut` and `periodStart` are low.
- R10: When the frequency select goes from 0 to a valid value at a clock edge, `periodStart` is high on the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dutyCode | input | 7 | Duty code; 0 means always low, 127 means always high |
| freqSel | input | 5 | Slot divide ratio; 0 is invalid and idles the block |
| pwmOut | output | 1 | PWM waveform |
| periodStart | output | 1 | One-cycle pulse on the first cycle of each period |

## Verification
The bench builds the block with its default widths, a 7-bit code and a 5-bit select. This allows the full range of divide ratios, including the largest ratio of 31, where a period lasts 3968 cycles. The table loop measures whole periods one cycle at a time. It counts the high cycles and the distance between strobes, and checks that the high time is one unbroken run. These measurements cover the extreme codes 0, 1, 126 and 127 at several ratios. Directed runs change the code and the ratio partway through a period, park the block on select 0, and bring it back to a valid select.

// File: rtl/pwm7_pkg.sv
package pwm7_pkg;
  localparam int DUTY_W = 7;
  localparam int SEL_W  = 5;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // boundary: sample new duty code
    logic running;  // a valid divide ratio is active
  } pwmStrobe_t;
endpackage

// File: rtl/pwm7_ctrl.sv
module pwm7_ctrl
  import pwm7_pkg::*;
#(
  parameter int DUTY_W = pwm7_pkg::DUTY_W,
  parameter int SEL_W  = pwm7_pkg::SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  freqSel,
  output logic [DUTY_W-1:0] slotIdx,
  output logic              periodStart,
  output pwmStrobe_t        strobe
);
  localparam logic [DUTY_W-1:0] SLOT_LAST = {DUTY_W{1'b1}};

  logic [SEL_W-1:0]  selAct;
  logic [SEL_W-1:0]  preCnt;
  logic [DUTY_W-1:0] slotCnt;
  logic              startQ;
  logic              idle;
  logic              slotEnd;
  logic              periodEnd;
  logic              load;

  assign idle      = (selAct == '0);
  assign slotEnd   = (preCnt == SEL_W'(selAct - 1'b1));
  assign periodEnd = slotEnd && (slotCnt == SLOT_LAST);
  assign load      = idle || periodEnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      selAct  <= '0;
      preCnt  <= '0;
      slotCnt <= '0;
      startQ  <= 1'b0;
    end else if (load) begin
      selAct  <= freqSel;
      preCnt  <= '0;
      slotCnt <= '0;
      startQ  <= (freqSel != '0);
    end else begin
      startQ <= 1'b0;
      if (slotEnd) begin
        preCnt  <= '0;
        slotCnt <= slotCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign slotIdx        = slotCnt;
  assign periodStart    = startQ;
  assign strobe.load    = load;
  assign strobe.running = !idle;
endmodule

// File: rtl/pwm7_datapath.sv
module pwm7_datapath
  import pwm7_pkg::*;
#(
  parameter int DUTY_W = pwm7_pkg::DUTY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] dutyCode,
  input  logic [DUTY_W-1:0] slotIdx,
  input  pwmStrobe_t        strobe,
  output logic              pwmOut
);
  localparam logic [DUTY_W-1:0] CODE_FULL = {DUTY_W{1'b1}};

  logic [DUTY_W-1:0] codeAct;
  logic              fullOn;
  logic              inPulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      codeAct <= '0;
    end else if (strobe.load) begin
      codeAct <= dutyCode;
    end
  end

  // top code is pinned high so the (2^W-1)/2^W step is skipped
  assign fullOn  = (codeAct == CODE_FULL);
  assign inPulse = (slotIdx < codeAct);
  assign pwmOut  = strobe.running && (fullOn || inPulse);
endmodule

// File: rtl/pwm7_gen.sv
module pwm7_gen
  import pwm7_pkg::*;
#(
  parameter int DUTY_W = pwm7_pkg::DUTY_W,
  parameter int SEL_W  = pwm7_pkg::SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] dutyCode,
  input  logic [SEL_W-1:0]  freqSel,
  output logic              pwmOut,
  output logic              periodStart
);
  pwmStrobe_t        strobe;
  logic [DUTY_W-1:0] slotIdx;

  pwm7_ctrl #(.DUTY_W(DUTY_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .freqSel(freqSel),
    .slotIdx(slotIdx), .periodStart(periodStart), .strobe(strobe)
  );

  pwm7_datapath #(.DUTY_W(DUTY_W)) u_dp (
    .clk(clk), .rst(rst), .dutyCode(dutyCode),
    .slotIdx(slotIdx), .strobe(strobe), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm7_checker.sv
module pwm7_checker #(
  parameter int DUTY_W = 7,
  parameter int SEL_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [DUTY_W-1:0] dutyCode,
  input logic [SEL_W-1:0]  freqSel,
  input logic              pwmOut,
  input logic              periodStart
);
  localparam logic [DUTY_W-1:0] CODE_FULL = {DUTY_W{1'b1}};

  p_zero_low_r1: assert property (@(posedge clk) disable iff (rst)
    (periodStart && $past(dutyCode) == '0) |-> !pwmOut);

  p_pulse_leads_r2: assert property (@(posedge clk) disable iff (rst)
    (periodStart && $past(dutyCode) != '0) |-> pwmOut);

  p_full_high_r3: assert property (@(posedge clk) disable iff (rst)
    (periodStart && $past(dutyCode) == CODE_FULL) |-> pwmOut);

  p_no_start_invalid_r4: assert property (@(posedge clk) disable iff (rst)
    periodStart |-> ($past(freqSel) != '0));

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
    periodStart |=> !periodStart);

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!pwmOut && !periodStart));
endmodule

bind pwm7_gen pwm7_checker #(.DUTY_W(DUTY_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .dutyCode(dutyCode), .freqSel(freqSel),
  .pwmOut(pwmOut), .periodStart(periodStart)
);

// File: tb/test_pwm7_gen.sv
module test_pwm7_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] dutyCode = '0;
  logic [4:0] freqSel = '0;
  logic       pwmOut;
  logic       periodStart;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm7_gen i_pwm7_gen (
    .clk(clk), .rst(rst), .dutyCode(dutyCode), .freqSel(freqSel),
    .pwmOut(pwmOut), .periodStart(periodStart)
  );

  localparam int NVEC = 10;
  localparam int VEC_SEL [NVEC] = '{1, 1, 1, 1, 1, 3, 4, 31, 2, 7};
  localparam int VEC_CODE[NVEC] = '{0, 1, 64, 126, 127, 5, 100, 2, 127, 126};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expHigh(input int code, input int sel);
    if (code == 0) return 0;
    if (code == 127) return 128 * sel;
    return code * sel;
  endfunction

  // called at a negedge; finds next strobe and measures one full period
  task automatic measurePeriod(output int highCnt, output int lenCnt, output bit contiguous,
                               output bit found, input int changeAt,
                               input int newCode, input int newSel);
    int guard = 0;
    bit seenLow = 0;
    found = 0; highCnt = 0; lenCnt = 0; contiguous = 1;
    @(negedge clk);
    while (!periodStart && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    if (!periodStart) return;
    found = 1;
    do begin
      if (pwmOut) begin
        if (seenLow) contiguous = 0;
        highCnt++;
      end else begin
        seenLow = 1;
      end
      lenCnt++;
      if (lenCnt == changeAt) begin
        dutyCode = 7'(newCode);
        freqSel  = 5'(newSel);
      end
      @(negedge clk);
    end while (!periodStart && lenCnt < 5000);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 200000 && !done) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hi, len;
    bit contig, found;

    // R9: quiet during reset
    repeat (3) @(negedge clk);
    check(!pwmOut, "R9 pwm in reset", pwmOut, 0);
    check(!periodStart, "R9 strobe in reset", periodStart, 0);
    rst = 1'b0;

    // table walk: R1 R2 R3 R5
    for (int i = 0; i < NVEC; i++) begin
      dutyCode = 7'(VEC_CODE[i]);
      freqSel  = 5'(VEC_SEL[i]);
      measurePeriod(hi, len, contig, found, -1, 0, 0);
      check(found, "R5 strobe seen", found, 1);
      check(len == 128 * VEC_SEL[i], "R5 period length", len, 128 * VEC_SEL[i]);
      check(hi == expHigh(VEC_CODE[i], VEC_SEL[i]),
            (VEC_CODE[i] == 0) ? "R1 high count" :
            (VEC_CODE[i] == 127) ? "R3 high count" : "R2 high count",
            hi, expHigh(VEC_CODE[i], VEC_SEL[i]));
      check(contig, "R2 single run from start", contig, 1);
    end

    // R7: code change mid-period
    dutyCode = 7'd10; freqSel = 5'd1;
    measurePeriod(hi, len, contig, found, -1, 0, 0);
    measurePeriod(hi, len, contig, found, 50, 100, 1);
    check(hi == 10, "R7 running period keeps code", hi, 10);
    measurePeriod(hi, len, contig, found, -1, 0, 0);
    check(hi == 100, "R7 next period uses new code", hi, 100);

    // R8: select change mid-period
    measurePeriod(hi, len, contig, found, 60, 100, 3);
    check(len == 128, "R8 running period keeps length", len, 128);
    measurePeriod(hi, len, contig, found, -1, 0, 0);
    check(len == 384, "R8 next period uses new ratio", len, 384);
    check(hi == 300, "R8 high time at new ratio", hi, 300);

    // R4: invalid select idles
    dutyCode = 7'd127; freqSel = 5'd0;
    repeat (400) @(negedge clk);
    begin
      int highs = 0, strobes = 0;
      for (int k = 0; k < 600; k++) begin
        if (pwmOut) highs++;
        if (periodStart) strobes++;
        @(negedge clk);
      end
      check(highs == 0, "R4 output low on select 0", highs, 0);
      check(strobes == 0, "R4 no strobe on select 0", strobes, 0);
    end

    // R10: restart from idle
    freqSel = 5'd2;
    @(negedge clk);
    check(periodStart, "R10 strobe after valid select", periodStart, 1);
    check(pwmOut, "R3 full code high at restart", pwmOut, 1);
    @(negedge clk);
    check(!periodStart, "R6 strobe one cycle", periodStart, 0);

    // R9: reset mid-period
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!pwmOut, "R9 pwm after reset edge", pwmOut, 0);
    check(!periodStart, "R9 strobe after reset edge", periodStart, 0);
    rst = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule